// File: doc/BRIEF.md
# Pipelined Cyclic Shuffle Network

This block aligns a bus of soft messages with a check node processor in a semi-parallel LDPC decoder. The bus is sized for the largest expansion factor and carries one message per lane. Each message is 5 bits wide, with 1 sign bit and 4 magnitude bits. The caller supplies four inputs each step: the lane vector, the expansion factor Z in use, a base-matrix column address and a valid strobe. The address selects a shift value from an internal read-only table. The lanes are then rotated cyclically within the first Z positions.

A table entry can mark an all-zero submatrix instead of a shift. For such an entry the block raises a marker and drops the valid, so those lanes do not take part in the check update. An unsupported Z raises an error flag instead.

The table read is always registered. A parameter adds zero, one or two further register stages on the way to the check node. Data and flags move through these stages together.

Top module: `cyclic_shuffle_pipe`

## Requirements
- R1: When `out_valid` is high, output lane i (bits 5i+4..5i) equals input lane (i + s) mod Z of the accepted vector, for every i below Z, where s is the table shift.
- R2: When `out_valid` is high, every output lane at index Z or above is zero.
- R3: A table shift larger than or equal to Z is reduced modulo Z before the rotation. For example, shift 85 with Z = 24 rotates by 13.
- R4: An accepted step whose table entry marks an all-zero block gives `out_zero` high, `out_valid` low and an all-zero `out_vec`.
- R5: An accepted step with Z outside 24..96, or with Z not a multiple of 4, gives `out_err` high, `out_valid` low, `out_zero` low and an all-zero `out_vec`.
- R6: An accepted step shows at the outputs exactly 1 + PIPE_DEPTH clock cycles after the edge that samples it. Steps on back-to-back cycles come out on back-to-back cycles.
- R7: A cycle with `in_valid` low gives, at the same latency, all three flags low and an all-zero `out_vec`.
- R8: While `rst_n` is low at a clock edge, all flags and `out_vec` clear to zero. At most one of `out_valid`, `out_zero` and `out_err` is high at any time.
- R9: The table entry for address k is an all-zero block when k ≥ 24 or k mod 5 = 3. Otherwise it is the shift (37·k + 11) mod 96.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_vec | input | 480 | 96 lanes of 5-bit messages, lane 0 in bits 4..0 |
| in_valid | input | 1 | Step strobe |
| z_sel | input | 7 | Active expansion factor |
| tbl_addr | input | 5 | Base-matrix column address into the shift table |
| out_vec | output | 480 | Rotated and masked lanes toward the check node |
| out_valid | output | 1 | Rotated data is valid |
| out_zero | output | 1 | Step was an all-zero submatrix |
| out_err | output | 1 | Step carried an unsupported Z |

## Verification
A wrong shift reduction or index wrap shows up as misplaced lanes in `out_vec` at the step's output cycle. This is most visible when the shift is close to Z or exceeds it, and the vectors use lane patterns with distinct neighbours so that such errors are caught. A valid or flag token lost or duplicated in the register chain shows one cycle early or late. Back-to-back steps make that visible within two output cycles, at both depth 1 and depth 2. A broken Z check or table decode sets the wrong flag, or leaves stale lanes above Z, in the first step that uses such a value.

// File: rtl/cshuf_pkg.sv
// Shared types and the computed shift table for the cyclic shuffle network.
// Assumes table entries fit in a signed int; -1 marks an all-zero block.
package cshuf_pkg;

    typedef struct packed {
        logic valid;
        logic zero;
        logic err;
    } cshuf_flags_t;

    // Shift table content: computed rather than listed.
    function automatic int shift_entry(int k, int depth, int zmax);
        if (k >= depth || (k % 5) == 3) begin
            return -1;
        end
        return (37 * k + 11) % zmax;
    endfunction

endpackage

// File: rtl/cshuf_front.sv
// Front stage: reads the shift table, checks Z, reduces the shift modulo Z
// and registers the vector, Z, reduced shift and step flags.
// Assumes ZMIN > 0, so a few conditional subtractions complete the modulo.
module cshuf_front
    import cshuf_pkg::*;
#(
    parameter int LANES     = 96,
    parameter int MSG_W     = 5,
    parameter int ZMIN      = 24,
    parameter int ZMAX      = 96,
    parameter int ZSTEP     = 4,
    parameter int TBL_DEPTH = 24,
    parameter int ZW        = 7,
    parameter int AW        = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [LANES*MSG_W-1:0] in_vec,
    input  logic                   in_valid,
    input  logic [ZW-1:0]          z_sel,
    input  logic [AW-1:0]          tbl_addr,
    output logic [LANES*MSG_W-1:0] f_vec,
    output logic [ZW-1:0]          f_z,
    output logic [ZW-1:0]          f_shift,
    output cshuf_flags_t           f_flags
);

    localparam int          REDUCE_STEPS = ZMAX / ZMIN + 1;
    localparam logic [ZW-1:0] ZMIN_V  = ZW'(ZMIN);
    localparam logic [ZW-1:0] ZMAX_V  = ZW'(ZMAX);
    localparam logic [ZW-1:0] ZSTEP_V = ZW'(ZSTEP);

    int              entry;
    logic            z_ok;
    logic            blk_zero;
    logic [ZW-1:0]   s_red;

    // Table lookup, Z legality and shift reduction for the current step.
    always_comb begin
        entry    = shift_entry(int'(tbl_addr), TBL_DEPTH, ZMAX);
        blk_zero = (entry < 0);
        z_ok     = (z_sel >= ZMIN_V) && (z_sel <= ZMAX_V) && ((z_sel % ZSTEP_V) == '0);
        s_red    = blk_zero ? '0 : ZW'(entry);
        for (int r = 0; r < REDUCE_STEPS; r++) begin
            if (z_ok && s_red >= z_sel) begin
                s_red = s_red - z_sel;
            end
        end
    end

    // Register the step: this is the fixed table-read cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_vec   <= '0;
            f_z     <= '0;
            f_shift <= '0;
            f_flags <= '0;
        end else begin
            f_vec         <= in_vec;
            f_z           <= z_sel;
            f_shift       <= s_red;
            f_flags.valid <= in_valid && z_ok && !blk_zero;
            f_flags.zero  <= in_valid && z_ok && blk_zero;
            f_flags.err   <= in_valid && !z_ok;
        end
    end

endmodule

// File: rtl/cshuf_rotate.sv
// Combinational rotator: output lane i takes lane (i + shift) mod z for
// i < z; lanes at z and above, and all lanes of a non-valid step, are zero.
// Assumes shift < z whenever flags.valid is high.
module cshuf_rotate
    import cshuf_pkg::*;
#(
    parameter int LANES = 96,
    parameter int MSG_W = 5,
    parameter int ZW    = 7
) (
    input  logic [LANES*MSG_W-1:0] r_vec,
    input  logic [ZW-1:0]          r_z,
    input  logic [ZW-1:0]          r_shift,
    input  cshuf_flags_t           r_flags,
    output logic [LANES*MSG_W-1:0] rot_vec
);

    // Per-lane source index with one wrap and the upper-lane mask.
    always_comb begin
        rot_vec = '0;
        for (int i = 0; i < LANES; i++) begin
            logic [ZW:0] idx;
            idx = (ZW+1)'(i) + {1'b0, r_shift};
            if (idx >= {1'b0, r_z}) begin
                idx = idx - {1'b0, r_z};
            end
            if (r_flags.valid && ((ZW+1)'(i) < {1'b0, r_z}) && (int'(idx) < LANES)) begin
                rot_vec[i*MSG_W +: MSG_W] = r_vec[int'(idx)*MSG_W +: MSG_W];
            end
        end
    end

endmodule

// File: rtl/cshuf_pipe.sv
// Output register chain of DEPTH stages (0 = pass-through).
// Assumes DEPTH is 0, 1 or 2; data and flags share one bus.
module cshuf_pipe #(
    parameter int DEPTH = 1,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        if (DEPTH == 0) begin : g_comb
            assign q = d;
        end else begin : g_regs
            logic [W-1:0] stg [DEPTH];
            // First stage captures the rotator output.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[0] <= '0;
                else        stg[0] <= d;
            end
            for (genvar k = 1; k < DEPTH; k++) begin : g_more
                // Each further stage copies the one before it.
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[k] <= '0;
                    else        stg[k] <= stg[k-1];
                end
            end
            assign q = stg[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/cyclic_shuffle_pipe.sv
// Top: table read and Z check, modulo-Z rotation, then PIPE_DEPTH output
// registers. Latency from input sample to outputs is 1 + PIPE_DEPTH cycles.
module cyclic_shuffle_pipe
    import cshuf_pkg::*;
#(
    parameter int LANES      = 96,
    parameter int MSG_W      = 5,
    parameter int ZMIN       = 24,
    parameter int ZMAX       = 96,
    parameter int ZSTEP      = 4,
    parameter int TBL_DEPTH  = 24,
    parameter int PIPE_DEPTH = 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [LANES*MSG_W-1:0]        in_vec,
    input  logic                          in_valid,
    input  logic [$clog2(ZMAX+1)-1:0]     z_sel,
    input  logic [$clog2(TBL_DEPTH+8)-1:0] tbl_addr,
    output logic [LANES*MSG_W-1:0]        out_vec,
    output logic                          out_valid,
    output logic                          out_zero,
    output logic                          out_err
);

    localparam int ZW    = $clog2(ZMAX + 1);
    localparam int AW    = $clog2(TBL_DEPTH + 8);
    localparam int VEC_W = LANES * MSG_W;
    localparam int BUS_W = VEC_W + 3;

    logic [VEC_W-1:0] f_vec;
    logic [ZW-1:0]    f_z;
    logic [ZW-1:0]    f_shift;
    cshuf_flags_t     f_flags;
    logic [VEC_W-1:0] rot_vec;
    logic [BUS_W-1:0] p_in;
    logic [BUS_W-1:0] p_out;
    cshuf_flags_t     o_flags;

    cshuf_front #(
        .LANES(LANES), .MSG_W(MSG_W), .ZMIN(ZMIN), .ZMAX(ZMAX),
        .ZSTEP(ZSTEP), .TBL_DEPTH(TBL_DEPTH), .ZW(ZW), .AW(AW)
    ) u_front (
        .clk(clk), .rst_n(rst_n), .in_vec(in_vec), .in_valid(in_valid),
        .z_sel(z_sel), .tbl_addr(tbl_addr), .f_vec(f_vec), .f_z(f_z),
        .f_shift(f_shift), .f_flags(f_flags)
    );

    cshuf_rotate #(.LANES(LANES), .MSG_W(MSG_W), .ZW(ZW)) u_rot (
        .r_vec(f_vec), .r_z(f_z), .r_shift(f_shift), .r_flags(f_flags),
        .rot_vec(rot_vec)
    );

    // Flags travel beside the data through the output chain.
    assign p_in = {f_flags, rot_vec};

    cshuf_pipe #(.DEPTH(PIPE_DEPTH), .W(BUS_W)) u_pipe (
        .clk(clk), .rst_n(rst_n), .d(p_in), .q(p_out)
    );

    assign o_flags   = p_out[BUS_W-1 -: 3];
    assign out_vec   = p_out[VEC_W-1:0];
    assign out_valid = o_flags.valid;
    assign out_zero  = o_flags.zero;
    assign out_err   = o_flags.err;

endmodule

// File: rtl/cshuf_checker.sv
// Assertion checker bound to cyclic_shuffle_pipe; relates outputs to the
// inputs sampled 1 + PIPE_DEPTH cycles earlier.
module cshuf_checker #(
    parameter int LANES      = 96,
    parameter int MSG_W      = 5,
    parameter int ZMIN       = 24,
    parameter int ZMAX       = 96,
    parameter int ZSTEP      = 4,
    parameter int TBL_DEPTH  = 24,
    parameter int PIPE_DEPTH = 1
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [LANES*MSG_W-1:0]         in_vec,
    input logic                           in_valid,
    input logic [$clog2(ZMAX+1)-1:0]      z_sel,
    input logic [$clog2(TBL_DEPTH+8)-1:0] tbl_addr,
    input logic [LANES*MSG_W-1:0]         out_vec,
    input logic                           out_valid,
    input logic                           out_zero,
    input logic                           out_err
);

    localparam int LAT = 1 + PIPE_DEPTH;

    a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({out_valid, out_zero, out_err}));

    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid, LAT) |-> !(out_valid || out_zero || out_err));

    a_r6_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, LAT));

    a_r4_zero_blank: assert property (@(posedge clk) disable iff (!rst_n)
        out_zero |-> (out_vec == '0));

    a_r2_upper_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_vec >> (int'($past(z_sel, LAT)) * MSG_W)) == '0));

    a_r5_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> (int'($past(z_sel, LAT)) < ZMIN || int'($past(z_sel, LAT)) > ZMAX
                     || (int'($past(z_sel, LAT)) % ZSTEP) != 0));

endmodule

bind cyclic_shuffle_pipe cshuf_checker #(
    .LANES(LANES), .MSG_W(MSG_W), .ZMIN(ZMIN), .ZMAX(ZMAX), .ZSTEP(ZSTEP),
    .TBL_DEPTH(TBL_DEPTH), .PIPE_DEPTH(PIPE_DEPTH)
) u_chk (.*);

// File: tb/test_cyclic_shuffle_pipe.sv
// Self-checking bench: vector table walk, then reset and corner tests.
module test_cyclic_shuffle_pipe;

    localparam int LANES = 96;
    localparam int MSG_W = 5;
    localparam int VW    = LANES * MSG_W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [VW-1:0] in_vec = '0;
    logic          in_valid = 1'b0;
    logic [6:0]    z_sel = 7'd96;
    logic [4:0]    tbl_addr = '0;
    logic [VW-1:0] out_vec, d2_vec;
    logic          out_valid, out_zero, out_err;
    logic          d2_valid, d2_zero, d2_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    cyclic_shuffle_pipe #(.PIPE_DEPTH(1)) i_cyclic_shuffle_pipe (
        .clk(clk), .rst_n(rst_n), .in_vec(in_vec), .in_valid(in_valid),
        .z_sel(z_sel), .tbl_addr(tbl_addr), .out_vec(out_vec),
        .out_valid(out_valid), .out_zero(out_zero), .out_err(out_err)
    );

    cyclic_shuffle_pipe #(.PIPE_DEPTH(2)) i_cyclic_shuffle_pipe_d2 (
        .clk(clk), .rst_n(rst_n), .in_vec(in_vec), .in_valid(in_valid),
        .z_sel(z_sel), .tbl_addr(tbl_addr), .out_vec(d2_vec),
        .out_valid(d2_valid), .out_zero(d2_zero), .out_err(d2_err)
    );

    typedef struct packed {
        logic [6:0] z;
        logic [4:0] addr;
        logic [7:0] seed;
        logic       vld;
    } stim_t;

    localparam int NSTIM = 13;
    localparam stim_t STIM [NSTIM] = '{
        '{7'd96, 5'd0,  8'd1,  1'b1},
        '{7'd24, 5'd2,  8'd2,  1'b1},   // R3: shift 85 wraps to 13
        '{7'd48, 5'd1,  8'd3,  1'b1},
        '{7'd60, 5'd4,  8'd4,  1'b1},
        '{7'd28, 5'd6,  8'd5,  1'b1},
        '{7'd96, 5'd7,  8'd6,  1'b1},
        '{7'd40, 5'd3,  8'd7,  1'b1},   // zero block
        '{7'd26, 5'd0,  8'd8,  1'b1},   // bad Z
        '{7'd100,5'd1,  8'd9,  1'b1},   // bad Z
        '{7'd20, 5'd1,  8'd10, 1'b1},   // bad Z
        '{7'd96, 5'd0,  8'd11, 1'b0},   // idle
        '{7'd92, 5'd23, 8'd12, 1'b1},   // zero block
        '{7'd72, 5'd9,  8'd13, 1'b1}
    };

    function automatic logic [VW-1:0] pat(int seed);
        logic [VW-1:0] v = '0;
        for (int j = 0; j < LANES; j++) v[j*MSG_W +: MSG_W] = 5'((j * 7 + seed) % 32);
        return v;
    endfunction

    // R9 model of the shift table.
    function automatic int tbl(int k);
        if (k >= 24 || (k % 5) == 3) return -1;
        return (37 * k + 11) % 96;
    endfunction

    function automatic bit z_good(int z);
        return z >= 24 && z <= 96 && (z % 4) == 0;
    endfunction

    function automatic logic [VW-1:0] rot(int z, int s_raw, int seed);
        logic [VW-1:0] src = pat(seed);
        logic [VW-1:0] v   = '0;
        int s = s_raw % z;
        for (int i = 0; i < z; i++) v[i*MSG_W +: MSG_W] = src[((i + s) % z)*MSG_W +: MSG_W];
        return v;
    endfunction

    task automatic chk(string tag, logic [VW-1:0] act, logic [VW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected outputs for one step given its stimulus.
    task automatic expect_step(int z, int a, int seed, bit vld,
                               logic [VW-1:0] v, logic fv, logic fz, logic fe);
        bit ev, ez, ee;
        logic [VW-1:0] evec = '0;
        string t;
        ee = vld && !z_good(z);
        ez = vld && z_good(z) && tbl(a) < 0;
        ev = vld && z_good(z) && tbl(a) >= 0;
        if (ev) evec = rot(z, tbl(a), seed);
        t = ee ? "R5" : ez ? "R4" : !vld ? "R7" : "R1";
        chk({t, " flags"}, VW'({fv, fz, fe}), VW'({ev, ez, ee}));
        chk({t, " R2 vec"}, v, evec);
    endtask

    task automatic drive(int z, int a, int seed, bit vld);
        z_sel    = 7'(z);
        tbl_addr = 5'(a);
        in_vec   = pat(seed);
        in_valid = vld;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        // R8: reset clears everything.
        repeat (3) @(negedge clk);
        chk("R8 reset flags", VW'({out_valid, out_zero, out_err}), '0);
        chk("R8 reset vec", out_vec, '0);
        rst_n = 1'b1;

        // Table walk, one step at a time (latency 2 at depth 1).
        for (int k = 0; k < NSTIM; k++) begin
            @(negedge clk);
            drive(int'(STIM[k].z), int'(STIM[k].addr), int'(STIM[k].seed), STIM[k].vld);
            @(negedge clk);
            in_valid = 1'b0;
            @(negedge clk);
            expect_step(int'(STIM[k].z), int'(STIM[k].addr), int'(STIM[k].seed), STIM[k].vld,
                        out_vec, out_valid, out_zero, out_err);
        end

        // R9: address past the table is an all-zero block.
        @(negedge clk); drive(48, 30, 20, 1'b1);
        @(negedge clk); in_valid = 1'b0;
        @(negedge clk);
        chk("R9 out-of-range zero", VW'({out_valid, out_zero, out_err}), VW'(3'b010));

        // R6: back-to-back steps at depth 1 and depth 2.
        @(negedge clk); @(negedge clk);
        drive(96, 0, 30, 1'b1);
        @(negedge clk);
        drive(32, 4, 31, 1'b1);
        chk("R6 not early d1", VW'(out_valid), '0);
        @(negedge clk);
        in_valid = 1'b0;
        expect_step(96, 0, 30, 1'b1, out_vec, out_valid, out_zero, out_err);
        chk("R6 not early d2", VW'(d2_valid), '0);
        @(negedge clk);
        expect_step(32, 4, 31, 1'b1, out_vec, out_valid, out_zero, out_err);
        expect_step(96, 0, 30, 1'b1, d2_vec, d2_valid, d2_zero, d2_err);
        @(negedge clk);
        expect_step(32, 4, 31, 1'b1, d2_vec, d2_valid, d2_zero, d2_err);
        chk("R6 single token d1", VW'(out_valid), '0);

        // R8: synchronous reset mid-stream clears the chain.
        drive(96, 1, 40, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R8 reset mid-stream", VW'({out_valid, d2_valid}), '0);
        rst_n    = 1'b1;
        in_valid = 1'b0;

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule